// File: doc/BRIEF.md
# High-Side Drive Protection Supervisor

This block watches a motor driver for three unsafe conditions and produces one inhibit that switches off the high-side drive. The three conditions are a rotor that stays out of speed lock for too long, an external speed clock that has stopped, and a supply undervoltage flag. The first two are timed from a slow reference tick that a low-frequency oscillator delivers, one clock-wide pulse per period. The undervoltage flag comes from an external comparator that already has hysteresis.

A stall is latched as a constraint fault. The fault stays set until the supervisor sees stop, brake or a power-on reset. A missing clock is not latched: it lifts as soon as a clock edge shows up again. In the stop state both timers are held at zero. When the oscillator-enable input is low, both timed protections are unused and only the undervoltage path remains.

Top module: `drive_guard`

## Requirements
- R1: After power-on reset (`rst_n` low), `hs_inhibit` and `stall_fault` are 0.
- R2: In run mode (`stop_req`=0, `brake_req`=0, `ref_osc_en`=1), if `lock_ok` stays 0, `stall_fault` goes to 1 in the cycle after the STALL_TICKS-th `ref_tick` pulse, and not earlier.
- R3: Any cycle with `lock_ok`=1 in run mode restarts the stall count from zero.
- R4: Once set, `stall_fault` stays 1 after `lock_ok` returns to 1 and while ticks and clock edges continue.
- R5: `stall_fault` clears in the cycle after `stop_req` or `brake_req` is 1. While brake is held the stall count stays at zero.
- R6: When `stop_req`=0 and `ref_osc_en`=1, `hs_inhibit` goes to 1 in the cycle after the LOSS_TICKS-th (default 2) `ref_tick` pulse with no `clk_edge` since the last edge or since leaving stop.
- R7: A `clk_edge` pulse clears the clock-loss inhibit in the next cycle. An edge in the same cycle as a tick takes priority, and the miss count then starts again from zero.
- R8: `hs_inhibit` follows `uv_flag` in the same cycle, with no register in the path.
- R9: In stop (`stop_req`=1) ticks have no effect. After leaving stop, both counts start from zero.
- R10: With `ref_osc_en`=0, neither a stall fault nor a clock loss is raised, whatever the ticks are. A latched stall fault also clears.
- R11: `hs_inhibit` is 1 whenever the stall fault, the clock loss or the undervoltage flag is active, and 0 when none of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ref_tick | input | 1 | One-cycle pulse per slow reference period |
| ref_osc_en | input | 1 | 1 when the slow oscillator is fitted; 0 disables the timed protections |
| lock_ok | input | 1 | 1 when the motor speed is inside the lock window |
| clk_edge | input | 1 | One-cycle pulse for each external speed-clock edge |
| uv_flag | input | 1 | 1 while the supply is under voltage |
| stop_req | input | 1 | 1 selects the stop state |
| brake_req | input | 1 | 1 selects brake |
| hs_inhibit | output | 1 | 1 turns the high-side drive off |
| stall_fault | output | 1 | Latched constraint fault |

## Verification
The bench goes after the timeout boundary. A count that is off by one would raise the fault one tick early or one tick late, and the check at tick STALL_TICKS-1 catches that. A single-cycle lock pulse in the middle of a stall is used to expose a design that only pauses its counter instead of restarting it. It also drives a clock edge and a tick in the same cycle: a design with the wrong priority would stay in clock loss, or would declare loss one tick early afterwards. Finally it checks that the stall latch survives the return of lock, that stop and a disabled oscillator wipe the state, and that undervoltage reaches the inhibit without a cycle of delay.

// File: rtl/drive_guard_pkg.sv
package drive_guard_pkg;

  typedef enum logic [1:0] {
    GM_IDLE  = 2'd0,
    GM_BRAKE = 2'd1,
    GM_RUN   = 2'd2
  } guard_mode_t;

  function automatic guard_mode_t decode_mode(input logic stop, input logic brake);
    if (stop)       return GM_IDLE;
    else if (brake) return GM_BRAKE;
    else            return GM_RUN;
  endfunction

  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/guard_stall_timer.sv
module guard_stall_timer #(
  parameter int unsigned LIMIT = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  input  logic lock_ok,
  output logic fault
);
  import drive_guard_pkg::*;

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = tick && !lock_ok && (int'(cnt) == int'(LIMIT) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (hold) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      if (lock_ok)   cnt <= '0;
      else if (tick) cnt <= CW'(sat_inc(int'(cnt), LIMIT));
      if (expire)    fault <= 1'b1;
    end
  end

  // R4: a set fault stays set until released
  a_r4_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !hold) |=> fault);
  // R5: stop, brake or disabled oscillator releases the fault
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !fault);
  // R3: a cycle in lock cannot raise the fault
  a_r3_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && lock_ok) |=> !fault);
endmodule

// File: rtl/guard_clk_watch.sv
module guard_clk_watch #(
  parameter int unsigned LOSS_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  input  logic clk_edge,
  output logic lost
);
  import drive_guard_pkg::*;

  localparam int unsigned MW = $clog2(LOSS_TICKS + 1);

  logic [MW-1:0] miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         miss <= '0;
    else if (hold)      miss <= '0;
    else if (clk_edge)  miss <= '0;
    else if (tick)      miss <= MW'(sat_inc(int'(miss), LOSS_TICKS));
  end

  assign lost = (int'(miss) == int'(LOSS_TICKS));

  // R7: an edge clears clock loss on the next cycle
  a_r7_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clk_edge |=> !lost);
  // R9: held watcher never reports loss
  a_r9_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !lost);
  // R6: loss only appears on a tick
  a_r6_loss_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!lost && !tick) |=> !lost);
endmodule

// File: rtl/drive_guard.sv
module drive_guard #(
  parameter int unsigned STALL_TICKS = 70,
  parameter int unsigned LOSS_TICKS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic ref_osc_en,
  input  logic lock_ok,
  input  logic clk_edge,
  input  logic uv_flag,
  input  logic stop_req,
  input  logic brake_req,
  output logic hs_inhibit,
  output logic stall_fault
);
  import drive_guard_pkg::*;

  guard_mode_t mode;
  logic        stall_hold;
  logic        watch_hold;
  logic        clk_lost;

  assign mode       = decode_mode(stop_req, brake_req);
  assign stall_hold = (mode != GM_RUN) || !ref_osc_en;
  assign watch_hold = (mode == GM_IDLE) || !ref_osc_en;

  guard_stall_timer #(.LIMIT(STALL_TICKS)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (stall_hold),
    .tick    (ref_tick),
    .lock_ok (lock_ok),
    .fault   (stall_fault)
  );

  guard_clk_watch #(.LOSS_TICKS(LOSS_TICKS)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (watch_hold),
    .tick     (ref_tick),
    .clk_edge (clk_edge),
    .lost     (clk_lost)
  );

  assign hs_inhibit = stall_fault | clk_lost | uv_flag;

  // R10: without the oscillator neither timed protection can be active
  a_r10_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_osc_en |=> (!stall_fault && !clk_lost));
  // R11: a latched stall always inhibits the drive
  a_r11_stall_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fault |-> hs_inhibit);
  // R1: state released on reset exit
  a_r1_reset_clean: assert property (@(posedge clk)
    $rose(rst_n) |-> !stall_fault);
endmodule

// File: tb/drive_guard_bench.sv
module drive_guard_bench;
  localparam int unsigned STALL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, ref_osc_en = 1'b1, lock_ok = 1'b0, clk_edge = 1'b0;
  logic uv_flag = 1'b0, stop_req = 1'b1, brake_req = 1'b0;
  logic hs_inhibit, stall_fault;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  drive_guard #(.STALL_TICKS(STALL), .LOSS_TICKS(2)) u_drive_guard (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ref_osc_en(ref_osc_en),
    .lock_ok(lock_ok), .clk_edge(clk_edge), .uv_flag(uv_flag),
    .stop_req(stop_req), .brake_req(brake_req),
    .hs_inhibit(hs_inhibit), .stall_fault(stall_fault));

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input logic with_edge);
    @(negedge clk); ref_tick = 1'b1; clk_edge = with_edge;
    @(negedge clk); ref_tick = 1'b0; clk_edge = 1'b0;
  endtask

  task automatic edge_pulse();
    @(negedge clk); clk_edge = 1'b1;
    @(negedge clk); clk_edge = 1'b0;
  endtask

  task automatic tick_fed();
    edge_pulse();
    tick(1'b0);
  endtask

  task automatic t_reset();
    idle(2);
    check(hs_inhibit, 1'b0, "R1 inhibit in reset");
    check(stall_fault, 1'b0, "R1 fault in reset");
    rst_n = 1'b1;
    idle(2);
    check(hs_inhibit, 1'b0, "R1 inhibit after reset");
  endtask

  task automatic t_stall();
    stop_req = 1'b0; lock_ok = 1'b0;
    for (int i = 0; i < int'(STALL) - 1; i++) tick_fed();
    check(stall_fault, 1'b0, "R2 no fault before timeout");
    check(hs_inhibit, 1'b0, "R2 no inhibit before timeout");
    tick_fed();
    check(stall_fault, 1'b1, "R2 fault at timeout");
    check(hs_inhibit, 1'b1, "R11 stall inhibits");
    lock_ok = 1'b1;
    tick_fed(); tick_fed();
    check(stall_fault, 1'b1, "R4 fault latched after lock");
    @(negedge clk); brake_req = 1'b1;
    @(negedge clk);
    check(stall_fault, 1'b0, "R5 brake releases");
    lock_ok = 1'b0;
    for (int i = 0; i < int'(STALL) + 1; i++) tick_fed();
    check(stall_fault, 1'b0, "R5 no count under brake");
    brake_req = 1'b0;
    idle(1);
    check(hs_inhibit, 1'b0, "R11 none active");
  endtask

  task automatic t_restart();
    lock_ok = 1'b0;
    for (int i = 0; i < 3; i++) tick_fed();
    @(negedge clk); lock_ok = 1'b1;
    @(negedge clk); lock_ok = 1'b0;
    for (int i = 0; i < int'(STALL) - 1; i++) tick_fed();
    check(stall_fault, 1'b0, "R3 lock restarts count");
    tick_fed();
    check(stall_fault, 1'b1, "R3 fault after full count");
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk);
    check(stall_fault, 1'b0, "R5 stop releases");
  endtask

  task automatic t_clock_loss();
    stop_req = 1'b0; lock_ok = 1'b1;
    edge_pulse();
    tick(1'b0);
    check(hs_inhibit, 1'b0, "R6 one missed tick");
    tick(1'b0);
    check(hs_inhibit, 1'b1, "R6 loss at second tick");
    check(stall_fault, 1'b0, "R11 loss not latched as stall");
    edge_pulse();
    check(hs_inhibit, 1'b0, "R7 edge resumes");
    tick(1'b0); tick(1'b0);
    check(hs_inhibit, 1'b1, "R6 loss again");
    tick(1'b1);
    check(hs_inhibit, 1'b0, "R7 edge wins over tick");
    tick(1'b0);
    check(hs_inhibit, 1'b0, "R7 count restarted");
    tick(1'b0);
    check(hs_inhibit, 1'b1, "R7 loss after restart");
  endtask

  task automatic t_stop_hold();
    @(negedge clk); stop_req = 1'b1; lock_ok = 1'b0;
    @(negedge clk);
    check(hs_inhibit, 1'b0, "R9 stop clears loss");
    for (int i = 0; i < int'(STALL) + 2; i++) tick(1'b0);
    check(hs_inhibit, 1'b0, "R9 ticks ignored in stop");
    check(stall_fault, 1'b0, "R9 no fault in stop");
    stop_req = 1'b0;
    tick(1'b0);
    check(hs_inhibit, 1'b0, "R9 count from zero after stop");
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_osc_off();
    ref_osc_en = 1'b0; stop_req = 1'b0; lock_ok = 1'b0;
    for (int i = 0; i < int'(STALL) + 2; i++) tick(1'b0);
    check(hs_inhibit, 1'b0, "R10 no protection without oscillator");
    check(stall_fault, 1'b0, "R10 no fault without oscillator");
    ref_osc_en = 1'b1;
    for (int i = 0; i < int'(STALL); i++) tick_fed();
    check(stall_fault, 1'b1, "R10 fault with oscillator");
    @(negedge clk); ref_osc_en = 1'b0;
    @(negedge clk);
    check(stall_fault, 1'b0, "R10 disable clears fault");
    @(negedge clk); stop_req = 1'b1; ref_osc_en = 1'b1;
  endtask

  task automatic t_undervoltage();
    @(negedge clk); uv_flag = 1'b1;
    #1;
    check(hs_inhibit, 1'b1, "R8 uv same cycle");
    @(negedge clk); uv_flag = 1'b0;
    #1;
    check(hs_inhibit, 1'b0, "R8 uv release");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stall();
    t_restart();
    t_clock_loss();
    t_stop_hold();
    t_osc_off();
    t_undervoltage();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule